// File: doc/BRIEF.md
# DMA Descriptor Fetch Sequencer

This block loads transfer descriptors on behalf of a DMA transfer engine. When an activation request arrives with a source number, it reads a 32-bit entry from a vector table at a configurable base address. That entry points to a descriptor in memory. The block then reads the descriptor one longword at a time over a simple 32-bit read port with a request/valid handshake. It unpacks the words into mode, source address, destination address and count registers, and announces them with a one-cycle valid pulse.

Two descriptor packings are supported, and a mode input sampled at activation picks one of them:

- **Full packing:** four longwords per descriptor.
- **Compact packing:** three longwords per descriptor. Each address has only 24 stored bits, and the top byte is rebuilt as all ones.

After each descriptor, the transfer engine either asks for the next one in the chain or ends the sequence. Chained descriptors lie back to back, 16 bytes apart in full packing and 12 bytes apart in compact packing.

Top module: `dfetch_top`

## Requirements
- R1: After synchronous reset, `busy`, `mem_req` and `desc_valid` are all 0.
- R2: The first read after an accepted activation goes to `(vec_base + 4*act_src)` with the two lowest bits cleared.
- R3: The descriptor start address is the vector entry with bits 1:0 forced to zero.
- R4: In full packing (`short_mode`=0), four reads are made per descriptor, at start, start+4, start+8 and start+12.
- R5: In compact packing (`short_mode`=1), three reads are made per descriptor, at start, start+4 and start+8.
- R6: The full packing is unpacked as follows. Word 0 bits 31:24 go to `mode_a` and bits 23:16 go to `mode_b`. Word 1 goes to `src_addr` and word 2 goes to `dst_addr`. Word 3 bits 31:16 go to `cnt_a` and bits 15:0 go to `cnt_b`.
- R7: The compact packing is unpacked as follows. Word 0 bits 31:24 go to `mode_a`, and `src_addr` is 8'hFF followed by word 0 bits 23:0. Word 1 bits 31:24 go to `mode_b`, and `dst_addr` is 8'hFF followed by word 1 bits 23:0. Word 2 bits 31:16 go to `cnt_a` and bits 15:0 go to `cnt_b`.
- R8: On `chain_go`, the next descriptor is read from the previous start plus 16 (full packing) or plus 12 (compact packing).
- R9: `mem_req` is a one-cycle pulse, and a new request is never issued while a read is still awaiting `mem_rvalid`.
- R10: `desc_valid` pulses for one cycle once all words of a descriptor have arrived. No further read is issued until `chain_go` or `chain_end`.
- R11: `busy` rises on the cycle after an accepted `act_req` and falls on the cycle after `chain_end`.
- R12: `short_mode` is sampled only when an activation is accepted. Changing it during a sequence does not alter that sequence.
- R13: `act_req` is ignored while `busy` is high. No extra vector read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_req | input | 1 | Activation request pulse |
| act_src | input | SRC_W | Activation source number |
| short_mode | input | 1 | 1 selects the compact three-longword packing |
| vec_base | input | 32 | Byte base address of the vector table |
| chain_go | input | 1 | Engine asks for the next chained descriptor |
| chain_end | input | 1 | Engine ends the sequence |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Read byte address, longword aligned |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| desc_valid | output | 1 | One-cycle pulse: descriptor fields are valid |
| mode_a | output | 8 | Mode byte A |
| mode_b | output | 8 | Mode byte B |
| src_addr | output | 32 | Source address |
| dst_addr | output | 32 | Destination address |
| cnt_a | output | 16 | Count A |
| cnt_b | output | 16 | Count B |

## Verification
The assertions check the following on every cycle:

- the request pulse shape and the single-outstanding-read rule;
- alignment of every request address;
- the one-cycle valid pulse;
- the absence of reads while the engine decides;
- the busy framing;
- the all-ones top byte of compact addresses.

The directed scenarios are the only way to show the following:

- the exact address sequence;
- the field mapping in both packings;
- the chain stride;
- that a mode change or a second activation in mid-sequence has no effect.

These are checked against a memory model with fixed latency.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;
  localparam int AW = 32;
  localparam int NW_FULL = 4;
  localparam int NW_SHORT = 3;
  localparam int IDX_W = $clog2(NW_FULL);

  typedef struct packed {
    logic [7:0]    mode_a;
    logic [7:0]    mode_b;
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [15:0]   cnt_a;
    logic [15:0]   cnt_b;
  } desc_t;

  typedef enum logic [2:0] {
    S_IDLE, S_VWAIT, S_DWAIT, S_EMIT, S_HOLD
  } st_t;
endpackage

// File: rtl/dfetch_addr.sv
module dfetch_addr
  import dfetch_pkg::*;
#(
  parameter int SRC_W = 4
) (
  input  logic [AW-1:0]    vec_base,
  input  logic [SRC_W-1:0] src_idx,
  input  logic [AW-1:0]    rdata,
  input  logic [AW-1:0]    cur_ptr,
  input  logic             short_q,
  output logic [AW-1:0]    vec_addr,
  output logic [AW-1:0]    ptr_aligned,
  output logic [AW-1:0]    next_ptr
);
  localparam logic [AW-1:0] STRIDE_FULL  = AW'(NW_FULL * 4);
  localparam logic [AW-1:0] STRIDE_SHORT = AW'(NW_SHORT * 4);
  localparam logic [AW-1:0] ALIGN_MASK   = ~AW'(3);

  always_comb begin
    vec_addr    = (vec_base + AW'({src_idx, 2'b00})) & ALIGN_MASK;
    ptr_aligned = rdata & ALIGN_MASK;
    next_ptr    = cur_ptr + (short_q ? STRIDE_SHORT : STRIDE_FULL);
  end
endmodule

// File: rtl/dfetch_unpack.sv
module dfetch_unpack
  import dfetch_pkg::*;
#(
  parameter logic [7:0] HI_FILL = 8'hFF
) (
  input  logic [AW-1:0] w0,
  input  logic [AW-1:0] w1,
  input  logic [AW-1:0] w2,
  input  logic [AW-1:0] w3,
  input  logic          short_q,
  output desc_t         d
);
  always_comb begin
    d.mode_a = w0[31:24];
    if (short_q) begin
      d.mode_b = w1[31:24];
      d.src    = {HI_FILL, w0[23:0]};
      d.dst    = {HI_FILL, w1[23:0]};
      d.cnt_a  = w2[31:16];
      d.cnt_b  = w2[15:0];
    end else begin
      d.mode_b = w0[23:16];
      d.src    = w1;
      d.dst    = w2;
      d.cnt_a  = w3[31:16];
      d.cnt_b  = w3[15:0];
    end
  end
endmodule

// File: rtl/dfetch_top.sv
module dfetch_top
  import dfetch_pkg::*;
#(
  parameter int SRC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_req,
  input  logic [SRC_W-1:0] act_src,
  input  logic             short_mode,
  input  logic [31:0]      vec_base,
  input  logic             chain_go,
  input  logic             chain_end,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic             desc_valid,
  output logic [7:0]       mode_a,
  output logic [7:0]       mode_b,
  output logic [31:0]      src_addr,
  output logic [31:0]      dst_addr,
  output logic [15:0]      cnt_a,
  output logic [15:0]      cnt_b
);
  st_t              st;
  logic             short_q;
  logic [AW-1:0]    ptr;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;
  logic [AW-1:0]    wbuf [NW_FULL];
  logic [AW-1:0]    vec_addr, ptr_aligned, next_ptr;
  desc_t            unpacked, d_q;

  assign last_idx = short_q ? IDX_W'(NW_SHORT - 1) : IDX_W'(NW_FULL - 1);

  dfetch_addr #(.SRC_W(SRC_W)) u_addr (
    .vec_base(vec_base), .src_idx(act_src), .rdata(mem_rdata),
    .cur_ptr(ptr), .short_q(short_q),
    .vec_addr(vec_addr), .ptr_aligned(ptr_aligned), .next_ptr(next_ptr)
  );

  dfetch_unpack u_unpack (
    .w0(wbuf[0]), .w1(wbuf[1]), .w2(wbuf[2]), .w3(wbuf[3]),
    .short_q(short_q), .d(unpacked)
  );

  // Word buffer: no reset, single write port
  always_ff @(posedge clk) begin
    if (st == S_DWAIT && mem_rvalid) wbuf[idx] <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      short_q    <= 1'b0;
      ptr        <= '0;
      idx        <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      busy       <= 1'b0;
      desc_valid <= 1'b0;
      d_q        <= '0;
    end else begin
      mem_req    <= 1'b0;
      desc_valid <= 1'b0;
      case (st)
        S_IDLE: if (act_req) begin
          short_q  <= short_mode;
          busy     <= 1'b1;
          mem_req  <= 1'b1;
          mem_addr <= vec_addr;
          st       <= S_VWAIT;
        end
        S_VWAIT: if (mem_rvalid) begin
          ptr      <= ptr_aligned;
          mem_addr <= ptr_aligned;
          mem_req  <= 1'b1;
          idx      <= '0;
          st       <= S_DWAIT;
        end
        S_DWAIT: if (mem_rvalid) begin
          if (idx == last_idx) begin
            st <= S_EMIT;
          end else begin
            idx      <= idx + 1'b1;
            mem_addr <= mem_addr + 32'd4;
            mem_req  <= 1'b1;
          end
        end
        S_EMIT: begin
          d_q        <= unpacked;
          desc_valid <= 1'b1;
          st         <= S_HOLD;
        end
        S_HOLD: if (chain_go) begin
          ptr      <= next_ptr;
          mem_addr <= next_ptr;
          mem_req  <= 1'b1;
          idx      <= '0;
          st       <= S_DWAIT;
        end else if (chain_end) begin
          busy <= 1'b0;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mode_a   = d_q.mode_a;
  assign mode_b   = d_q.mode_b;
  assign src_addr = d_q.src;
  assign dst_addr = d_q.dst;
  assign cnt_a    = d_q.cnt_a;
  assign cnt_b    = d_q.cnt_b;
endmodule

// File: rtl/dfetch_chk.sv
module dfetch_chk (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_rvalid,
  input logic [31:0] mem_addr,
  input logic        desc_valid,
  input logic        busy,
  input logic        chain_go,
  input logic        chain_end,
  input logic        short_q,
  input logic [31:0] src_addr,
  input logic [31:0] dst_addr
);
  logic outstanding, deciding;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= 1'b0;
      deciding    <= 1'b0;
    end else begin
      if (mem_req) outstanding <= 1'b1;
      else if (mem_rvalid) outstanding <= 1'b0;
      if (desc_valid) deciding <= 1'b1;
      else if (chain_go || chain_end) deciding <= 1'b0;
    end
  end

  a_r9_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    outstanding && !mem_rvalid |-> !mem_req);
  a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00);
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    desc_valid |=> !desc_valid);
  a_r10_no_read_deciding: assert property (@(posedge clk) disable iff (rst)
    deciding |-> !mem_req);
  a_r11_busy_frames: assert property (@(posedge clk) disable iff (rst)
    (mem_req || desc_valid) |-> busy);
  a_r11_busy_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(chain_end));
  a_r7_top_fill: assert property (@(posedge clk) disable iff (rst)
    desc_valid && short_q |-> (src_addr[31:24] == 8'hFF && dst_addr[31:24] == 8'hFF));
endmodule

bind dfetch_top dfetch_chk u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .mem_addr(mem_addr), .desc_valid(desc_valid), .busy(busy),
  .chain_go(chain_go), .chain_end(chain_end), .short_q(short_q),
  .src_addr(src_addr), .dst_addr(dst_addr)
);

// File: tb/dfetch_top_tb.sv
module dfetch_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        act_req = 1'b0;
  logic [3:0]  act_src = '0;
  logic        short_mode = 1'b0;
  logic [31:0] vec_base = 32'h10;
  logic        chain_go = 1'b0;
  logic        chain_end = 1'b0;
  logic        mem_req, mem_rvalid, busy, desc_valid;
  logic [31:0] mem_addr, mem_rdata, src_addr, dst_addr;
  logic [7:0]  mode_a, mode_b;
  logic [15:0] cnt_a, cnt_b;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dfetch_top #(.SRC_W(4)) u_dut (
    .clk(clk), .rst(rst), .act_req(act_req), .act_src(act_src),
    .short_mode(short_mode), .vec_base(vec_base), .chain_go(chain_go),
    .chain_end(chain_end), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy),
    .desc_valid(desc_valid), .mode_a(mode_a), .mode_b(mode_b),
    .src_addr(src_addr), .dst_addr(dst_addr), .cnt_a(cnt_a), .cnt_b(cnt_b)
  );

  // Memory model: 64 words, two-cycle latency
  logic [31:0] mem [64];
  logic        pend;
  logic [31:0] pa;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) pend <= 1'b0;
    else if (mem_req) begin
      pend <= 1'b1;
      pa   <= mem_addr;
    end else if (pend) begin
      pend       <= 1'b0;
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[pa[7:2]];
    end
  end

  // Log of request addresses
  logic [31:0] rlog [64];
  int rn = 0;
  always @(posedge clk) begin
    if (!rst && mem_req && rn < 64) begin
      rlog[rn] <= mem_addr;
      rn <= rn + 1;
    end
  end

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic start(input logic [3:0] s, input logic sm);
    @(negedge clk);
    act_req = 1'b1; act_src = s; short_mode = sm;
    @(negedge clk);
    act_req = 1'b0;
  endtask

  task automatic wait_desc(input string r);
    bit ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (desc_valid) begin ok = 1; break; end
    end
    chk({r, " desc_valid seen"}, 32'(ok), 32'd1);
  endtask

  task automatic pulse_go();
    @(negedge clk); chain_go = 1'b1;
    @(negedge clk); chain_go = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); chain_end = 1'b1;
    @(negedge clk); chain_end = 1'b0;
    chk("R11 busy low after end", 32'(busy), 32'd0);
  endtask

  task automatic check_fields(input string r, input logic [7:0] ma, input logic [7:0] mb,
                              input logic [31:0] s, input logic [31:0] d,
                              input logic [15:0] ca, input logic [15:0] cb);
    chk({r, " mode_a"}, 32'(mode_a), 32'(ma));
    chk({r, " mode_b"}, 32'(mode_b), 32'(mb));
    chk({r, " src"}, src_addr, s);
    chk({r, " dst"}, dst_addr, d);
    chk({r, " cnt_a"}, 32'(cnt_a), 32'(ca));
    chk({r, " cnt_b"}, 32'(cnt_b), 32'(cb));
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 desc_valid", 32'(desc_valid), 32'd0);
  endtask

  task automatic t_full_single();
    int b = rn;
    start(4'd1, 1'b0);
    chk("R11 busy after activation", 32'(busy), 32'd1);
    wait_desc("R10");
    check_fields("R6", 8'hA1, 8'hB2, 32'h12345678, 32'h9ABCDEF0, 16'h0010, 16'h0020);
    chk("R2 vector address", rlog[b], 32'h14);
    for (int k = 0; k < 4; k++)
      chk("R4 word address", rlog[b+1+k], 32'h40 + 32'(4*k));
    @(negedge clk);
    chk("R10 valid one cycle", 32'(desc_valid), 32'd0);
    repeat (6) @(negedge clk);
    chk("R4 R10 read count while waiting", 32'(rn - b), 32'd5);
    chk("R11 busy while waiting", 32'(busy), 32'd1);
    pulse_end();
  endtask

  task automatic t_full_chain();
    int b = rn;
    start(4'd1, 1'b0);
    // mid-sequence mode change and second activation
    short_mode = 1'b1;
    act_req = 1'b1; act_src = 4'd2;
    @(negedge clk);
    act_req = 1'b0;
    wait_desc("R12");
    check_fields("R12 first", 8'hA1, 8'hB2, 32'h12345678, 32'h9ABCDEF0, 16'h0010, 16'h0020);
    pulse_go();
    wait_desc("R8");
    check_fields("R8 R12 second", 8'hC3, 8'hD4, 32'h11111111, 32'h22222222, 16'h0003, 16'h0004);
    for (int k = 0; k < 4; k++)
      chk("R8 chained full address", rlog[b+5+k], 32'h50 + 32'(4*k));
    chk("R13 total reads", 32'(rn - b), 32'd9);
    short_mode = 1'b0;
    pulse_end();
  endtask

  task automatic t_short_chain();
    int b = rn;
    start(4'd2, 1'b1);
    short_mode = 1'b0;
    wait_desc("R7");
    check_fields("R7 first", 8'h5A, 8'h6B, 32'hFF123456, 32'hFF654321, 16'h0007, 16'h0008);
    chk("R2 vector address", rlog[b], 32'h18);
    for (int k = 0; k < 3; k++)
      chk("R3 R5 word address", rlog[b+1+k], 32'h80 + 32'(4*k));
    chk("R5 read count", 32'(rn - b), 32'd4);
    pulse_go();
    wait_desc("R8");
    check_fields("R7 second", 8'h7C, 8'h8D, 32'hFF00ABCD, 32'hFF00DCBA, 16'hFFFF, 16'h0001);
    for (int k = 0; k < 3; k++)
      chk("R8 chained short address", rlog[b+4+k], 32'h8C + 32'(4*k));
    chk("R8 R5 total reads", 32'(rn - b), 32'd7);
    pulse_end();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[5]  = 32'h0000_0040;  // vector entry for source 1 (base 0x10)
    mem[6]  = 32'h0000_0083;  // vector entry for source 2, misaligned
    mem[16] = 32'hA1B2_0000; mem[17] = 32'h1234_5678;
    mem[18] = 32'h9ABC_DEF0; mem[19] = 32'h0010_0020;
    mem[20] = 32'hC3D4_0000; mem[21] = 32'h1111_1111;
    mem[22] = 32'h2222_2222; mem[23] = 32'h0003_0004;
    mem[32] = 32'h5A12_3456; mem[33] = 32'h6B65_4321; mem[34] = 32'h0007_0008;
    mem[35] = 32'h7C00_ABCD; mem[36] = 32'h8D00_DCBA; mem[37] = 32'hFFFF_0001;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_single();
    t_full_chain();
    t_short_chain();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hang expected=completion");
    summary();
    $finish;
  end
endmodule